// File: doc/BRIEF.md
# Bus-Mapped Word FIFO Pair with Sticky Access Errors

This block sits between a register bus and one execution engine. It holds two small word queues. The bus fills the outbound queue, and the engine drains it through a valid/ready handshake. The engine fills the inbound queue with a push strobe, and the bus empties it by reading a data address. Full and empty flags for both queues are brought out to the interrupt logic.

Illegal bus accesses never disturb a queue. A write to a full outbound queue is dropped and leaves the pointers, count and stored words as they were. A read of an empty inbound queue changes nothing and returns zero. Each kind of fault raises its own sticky flag in an error register. Software clears a flag by writing a 1 to its bit.

Bus map (word addresses on `bus_addr`): 0 is outbound data (write pushes), 1 is inbound data (read pops), and 2 is the error register. In the error register, bit 0 is outbound overflow and bit 1 is inbound underflow; it is readable, and a write of 1 clears that bit. Read data is combinational and is valid in the same cycle as `bus_rd`.

Top module: `bus_fifo_pair`

## Requirements
- R1: After reset both queues are empty (`tx_empty`=1, `rx_empty`=1, both full flags 0, `eng_tx_valid`=0), and the error register at address 2 reads 0.
- R2: Each bus write to address 0 on a non-full outbound queue stores one word. The engine receives the words on `eng_tx_data` in write order, with one word removed per cycle in which `eng_tx_valid` and `eng_tx_ready` are both high.
- R3: A bus write to address 0 while `tx_full` is 1 leaves the outbound count and contents unchanged, and it sets error bit 0.
- R4: Each bus read of address 1 on a non-empty inbound queue returns the oldest word on `bus_rdata` in that cycle and removes it, so words come out in engine push order.
- R5: A bus read of address 1 while `rx_empty` is 1 returns 0, leaves the inbound queue unchanged, and sets error bit 1.
- R6: Error bits stay set until a bus write to address 2 has a 1 in that bit position. Writing 0 to a bit leaves it set. Clearing one bit leaves the other bit unchanged.
- R7: A cycle with both a bus push and an engine pop on an outbound queue that is neither full nor empty leaves its occupancy unchanged.
- R8: Each full flag is 1 exactly when its queue holds DEPTH words (4 by default). Each empty flag is 1 exactly when its queue holds none.
- R9: An engine push while `rx_full` is 1 is dropped and does not alter the inbound queue.
- R10: A bus write to address 1 does not change the inbound queue. A bus read of address 0 returns 0 and does not change the outbound queue.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Bus write strobe |
| bus_rd | input | 1 | Bus read strobe |
| bus_addr | input | ADDR_W | Bus word address |
| bus_wdata | input | DATA_W | Bus write data |
| bus_rdata | output | DATA_W | Bus read data, combinational |
| eng_tx_valid | output | 1 | Outbound queue has a word for the engine |
| eng_tx_data | output | DATA_W | Oldest outbound word |
| eng_tx_ready | input | 1 | Engine takes the outbound word |
| eng_rx_push | input | 1 | Engine pushes a word inbound |
| eng_rx_data | input | DATA_W | Word pushed by the engine |
| tx_full | output | 1 | Outbound queue full |
| tx_empty | output | 1 | Outbound queue empty |
| rx_full | output | 1 | Inbound queue full |
| rx_empty | output | 1 | Inbound queue empty |

## Verification
The outbound queue is filled with every count from zero to two past its depth, and then drained. This separates correct storage order from lost or duplicated words. It also shows whether the writes past full were dropped or wrongly overwrote an entry. The inbound queue is swept the same way. The reads stop exactly at the last stored word and then go one past it, so a missing underflow flag or a spurious one is caught. Further runs cover a push and a pop in the same cycle, with the full flag observed on the next write. They also cover accesses to the wrong-direction address and clearing of the error bits one at a time.

// File: rtl/bus_fifo_pair.sv
module bus_fifo_pair #(
  parameter int DATA_W = 32,
  parameter int DEPTH  = 4,
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              eng_tx_valid,
  output logic [DATA_W-1:0] eng_tx_data,
  input  logic              eng_tx_ready,
  input  logic              eng_rx_push,
  input  logic [DATA_W-1:0] eng_rx_data,
  output logic              tx_full,
  output logic              tx_empty,
  output logic              rx_full,
  output logic              rx_empty
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam logic [ADDR_W-1:0] A_TX  = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] A_RX  = ADDR_W'(1);
  localparam logic [ADDR_W-1:0] A_ERR = ADDR_W'(2);
  localparam logic [CNT_W-1:0]  FULL_CNT = CNT_W'(DEPTH);
  localparam logic [PW-1:0]     LAST = PW'(DEPTH - 1);

  logic [DATA_W-1:0] tx_mem [DEPTH];
  logic [DATA_W-1:0] rx_mem [DEPTH];
  logic [PW-1:0]     tx_wp, tx_rp, rx_wp, rx_rp;
  logic [CNT_W-1:0]  tx_cnt, rx_cnt;
  logic [1:0]        err_q;

  logic tx_wr_hit, rx_rd_hit, err_wr_hit;
  logic tx_push, tx_pop, rx_push, rx_pop;
  logic [1:0] err_set, err_clr;

  assign tx_full  = (tx_cnt == FULL_CNT);
  assign tx_empty = (tx_cnt == '0);
  assign rx_full  = (rx_cnt == FULL_CNT);
  assign rx_empty = (rx_cnt == '0);

  assign tx_wr_hit  = bus_wr && (bus_addr == A_TX);
  assign rx_rd_hit  = bus_rd && (bus_addr == A_RX);
  assign err_wr_hit = bus_wr && (bus_addr == A_ERR);

  assign tx_push = tx_wr_hit && !tx_full;
  assign tx_pop  = eng_tx_ready && !tx_empty;
  assign rx_push = eng_rx_push && !rx_full;
  assign rx_pop  = rx_rd_hit && !rx_empty;

  assign err_set = {rx_rd_hit && rx_empty, tx_wr_hit && tx_full};
  assign err_clr = err_wr_hit ? bus_wdata[1:0] : 2'b00;

  assign eng_tx_valid = !tx_empty;
  assign eng_tx_data  = tx_mem[tx_rp];

  always_comb begin
    bus_rdata = '0;
    if (bus_rd) begin
      if (bus_addr == A_RX && !rx_empty) bus_rdata = rx_mem[rx_rp];
      else if (bus_addr == A_ERR)        bus_rdata = DATA_W'(err_q);
    end
  end

  function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
    return (p == LAST) ? '0 : p + PW'(1);
  endfunction

  always_ff @(posedge clk) begin
    if (tx_push) tx_mem[tx_wp] <= bus_wdata;
    if (rx_push) rx_mem[rx_wp] <= eng_rx_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tx_wp  <= '0;
      tx_rp  <= '0;
      tx_cnt <= '0;
      rx_wp  <= '0;
      rx_rp  <= '0;
      rx_cnt <= '0;
      err_q  <= '0;
    end else begin
      if (tx_push) tx_wp <= bump(tx_wp);
      if (tx_pop)  tx_rp <= bump(tx_rp);
      if (tx_push && !tx_pop)      tx_cnt <= tx_cnt + CNT_W'(1);
      else if (tx_pop && !tx_push) tx_cnt <= tx_cnt - CNT_W'(1);
      if (rx_push) rx_wp <= bump(rx_wp);
      if (rx_pop)  rx_rp <= bump(rx_rp);
      if (rx_push && !rx_pop)      rx_cnt <= rx_cnt + CNT_W'(1);
      else if (rx_pop && !rx_push) rx_cnt <= rx_cnt - CNT_W'(1);
      err_q <= (err_q & ~err_clr) | err_set;
    end
  end
endmodule

module bus_fifo_pair_chk #(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 4,
  parameter int CNT_W  = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_wr,
  input logic              bus_rd,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [DATA_W-1:0] bus_wdata,
  input logic              eng_tx_ready,
  input logic              eng_rx_push,
  input logic              tx_full,
  input logic              tx_empty,
  input logic              rx_full,
  input logic              rx_empty,
  input logic [CNT_W-1:0]  tx_cnt,
  input logic [1:0]        err_q
);
  // R8
  tx_flags_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(tx_full && tx_empty));
  // R8
  rx_flags_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(rx_full && rx_empty));
  // R3
  tx_over_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == ADDR_W'(0) && tx_full) |=> err_q[0]);
  // R3
  tx_over_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == ADDR_W'(0) && tx_full && !eng_tx_ready) |=> $stable(tx_cnt));
  // R5
  rx_under_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && bus_addr == ADDR_W'(1) && rx_empty) |=> err_q[1]);
  // R5
  rx_under_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && bus_addr == ADDR_W'(1) && rx_empty && !eng_rx_push) |=> rx_empty);
  // R6
  err_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (err_q[0] && !(bus_wr && bus_addr == ADDR_W'(2) && bus_wdata[0])) |=> err_q[0]);
  // R7
  tx_both_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == ADDR_W'(0) && eng_tx_ready && !tx_full && !tx_empty)
      |=> $stable(tx_cnt));
endmodule

bind bus_fifo_pair bus_fifo_pair_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
  .bus_wdata(bus_wdata), .eng_tx_ready(eng_tx_ready), .eng_rx_push(eng_rx_push),
  .tx_full(tx_full), .tx_empty(tx_empty), .rx_full(rx_full), .rx_empty(rx_empty),
  .tx_cnt(tx_cnt), .err_q(err_q)
);

// File: tb/test_bus_fifo_pair.sv
`timescale 1ns/1ps
module test_bus_fifo_pair;
  localparam int DW = 32;
  localparam int D  = 4;
  localparam int AW = 4;

  logic clk = 0, rst_n = 0;
  logic bus_wr = 0, bus_rd = 0;
  logic [AW-1:0] bus_addr = '0;
  logic [DW-1:0] bus_wdata = '0, bus_rdata;
  logic eng_tx_valid, eng_tx_ready = 0, eng_rx_push = 0;
  logic [DW-1:0] eng_tx_data, eng_rx_data = '0;
  logic tx_full, tx_empty, rx_full, rx_empty;

  int checks = 0, errors = 0;
  logic [DW-1:0] rv;

  always #2.5 clk = ~clk;

  bus_fifo_pair #(.DATA_W(DW), .DEPTH(D), .ADDR_W(AW)) i_bus_fifo_pair (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .eng_tx_valid(eng_tx_valid),
    .eng_tx_data(eng_tx_data), .eng_tx_ready(eng_tx_ready), .eng_rx_push(eng_rx_push),
    .eng_rx_data(eng_rx_data), .tx_full(tx_full), .tx_empty(tx_empty),
    .rx_full(rx_full), .rx_empty(rx_empty));

  task automatic chk(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] d);
    @(negedge clk); bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_wr = 0;
  endtask

  task automatic rd(input logic [AW-1:0] a, output logic [DW-1:0] d);
    @(negedge clk); bus_rd = 1; bus_addr = a;
    #1 d = bus_rdata;
    @(negedge clk); bus_rd = 0;
  endtask

  task automatic tx_take(output logic [DW-1:0] d);
    @(negedge clk); d = eng_tx_data; eng_tx_ready = 1;
    @(negedge clk); eng_tx_ready = 0;
  endtask

  task automatic rx_put(input logic [DW-1:0] d);
    @(negedge clk); eng_rx_push = 1; eng_rx_data = d;
    @(negedge clk); eng_rx_push = 0;
  endtask

  initial begin
    #2000000;
    errors++;
    $display("FAIL watchdog actual=running expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1
    chk("R1 tx_empty", DW'(tx_empty), 1);
    chk("R1 rx_empty", DW'(rx_empty), 1);
    chk("R1 full", DW'({tx_full, rx_full}), 0);
    chk("R1 valid", DW'(eng_tx_valid), 0);
    rd(2, rv); chk("R1 err", rv, 0);

    // outbound sweep: R2 R3 R8
    for (int n = 0; n <= D + 2; n++) begin
      wr(2, 3);
      for (int i = 0; i < n; i++) wr(0, 32'hA000_0000 + n * 256 + i);
      chk("R8 tx_full", DW'(tx_full), DW'(n >= D));
      chk("R8 tx_empty", DW'(tx_empty), DW'(n == 0));
      rd(2, rv); chk("R3 overflow flag", DW'(rv[0]), DW'(n > D));
      for (int i = 0; i < ((n < D) ? n : D); i++) begin
        chk("R2 valid", DW'(eng_tx_valid), 1);
        tx_take(rv); chk("R2 order", rv, 32'hA000_0000 + n * 256 + i);
      end
      chk("R3 no extra words", DW'(tx_empty), 1);
    end

    // inbound sweep: R4 R5 R8 R9
    for (int n = 0; n <= D + 1; n++) begin
      wr(2, 3);
      for (int i = 0; i < n; i++) rx_put(32'hB000_0000 + n * 256 + i);
      chk(n > D ? "R9 rx_full" : "R8 rx_full", DW'(rx_full), DW'(n >= D));
      chk("R8 rx_empty", DW'(rx_empty), DW'(n == 0));
      for (int i = 0; i < ((n < D) ? n : D); i++) begin
        rd(1, rv); chk("R4 order", rv, 32'hB000_0000 + n * 256 + i);
      end
      rd(2, rv); chk("R5 no early underflow", DW'(rv[1]), 0);
      rd(1, rv); chk("R5 empty read zero", rv, 0);
      rd(2, rv); chk("R5 underflow flag", DW'(rv[1]), 1);
      chk("R5 still empty", DW'(rx_empty), 1);
    end

    // R6 sticky behaviour
    wr(2, 3);
    for (int i = 0; i <= D; i++) wr(0, i);
    rd(1, rv);
    rd(2, rv); chk("R6 both set", rv, 3);
    wr(2, 0);
    rd(2, rv); chk("R6 zero write keeps", rv, 3);
    wr(2, 1);
    rd(2, rv); chk("R6 clear bit0 only", rv, 2);
    wr(2, 2);
    rd(2, rv); chk("R6 clear bit1", rv, 0);
    for (int i = 0; i < D; i++) tx_take(rv);

    // R7 simultaneous push and pop at occupancy D-1
    for (int i = 0; i < D - 1; i++) wr(0, 32'hC000_0000 + i);
    @(negedge clk);
    bus_wr = 1; bus_addr = 0; bus_wdata = 32'hC000_00FF; eng_tx_ready = 1;
    @(negedge clk);
    bus_wr = 0; eng_tx_ready = 0;
    chk("R7 not full", DW'(tx_full), 0);
    wr(0, 32'hC000_0100);
    chk("R7 full after one more", DW'(tx_full), 1);
    for (int i = 1; i < D - 1; i++) begin
      tx_take(rv); chk("R7 order", rv, 32'hC000_0000 + i);
    end
    tx_take(rv); chk("R7 order", rv, 32'hC000_00FF);
    tx_take(rv); chk("R7 order", rv, 32'hC000_0100);
    chk("R7 empty", DW'(tx_empty), 1);

    // R10 wrong-direction accesses
    wr(2, 3);
    wr(1, 32'hDEAD_BEEF);
    chk("R10 rx untouched", DW'(rx_empty), 1);
    wr(0, 32'h1234_5678);
    rd(0, rv); chk("R10 tx read zero", rv, 0);
    chk("R10 tx kept", DW'(eng_tx_valid), 1);
    tx_take(rv); chk("R10 tx word", rv, 32'h1234_5678);
    chk("R10 tx single", DW'(tx_empty), 1);
    rd(2, rv); chk("R10 no errors", rv, 0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule